// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block decides when a small processor core stops executing instructions and when it starts again. The core's decode stage gives it one-cycle pulses for three instructions: wait-for-interrupt, wait-for-event and send-event. It also gives a pulse when the last exception handler returns to thread code. From the interrupt side the block sees each interrupt's pending level, enable bit and priority. It also sees the current execution priority and a global mask bit. Two control bits select the automatic sleep after handler return and the wake on any newly pending interrupt. The block drives a sleep level, a one-cycle wake pulse and a take-exception grant.

There are two ways into sleep, and each has its own wake rule. The wait-for-interrupt path and the handler-return path wake only on an interrupt that could be taken. The wait-for-event path uses a hidden one-bit event latch, and that latch can cancel the sleep before it starts. This path can also wake on any interrupt that has just become pending. A debug request wakes the core from either kind of sleep. Software is expected to put the core back to sleep from its idle loop after such a wake.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset `sleep_o`, `wake_o` and `take_exc_o` are 0 and the event latch is clear, so a first wait-for-event enters sleep.
- R2: A wait-for-interrupt pulse while awake, with no wake condition present, raises `sleep_o` on the next clock edge. An interrupt qualifies when its pending bit and its enable bit are both 1 and its priority is numerically lower than `cur_prio_i` (a lower value is more urgent). Interrupt i takes priority bits `irq_prio_i[i*PRIO_W +: PRIO_W]`.
- R3: A wait-for-interrupt or handler-return request does not enter sleep when a qualifying interrupt or a debug request is present in the same cycle.
- R4: A wait-for-event pulse with the event latch clear enters sleep. With the latch set, the core stays awake and the latch is cleared, so a second wait-for-event sleeps.
- R5: A send-event pulse sets the event latch. A debug request leaves the latch unchanged.
- R6: A handler-return pulse enters sleep only when `sleep_on_exit_i` is 1.
- R7: Sleep entered through wait-for-interrupt or handler return ends only on a qualifying interrupt or a debug request. A newly pending interrupt that is disabled or of low priority does not end it, even with `wake_any_pend_i` set.
- R8: Sleep entered through wait-for-event ends on a qualifying interrupt or a debug request. It also ends on a 0-to-1 change of any pending bit, but only while `wake_any_pend_i` is 1.
- R9: `wake_o` is high for exactly one cycle, and `sleep_o` falls in that same cycle.
- R10: `take_exc_o` is 1 only while awake, with a qualifying interrupt present and `primask_i` at 0. While the mask is set, a wake still happens but the grant is held back.
- R11: While `wake_any_pend_i` is 1, a 0-to-1 change of a pending bit sets the event latch, whether the core is awake or asleep. A pending bit that stays high does not count as a new event.
- R12: Simultaneous requests are ranked wait-for-interrupt, then wait-for-event, then handler return. A wait-for-event in the same cycle as an event-setting pulse uses up that event and stays awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_i | input | 1 | Wait-for-interrupt instruction pulse |
| wfe_i | input | 1 | Wait-for-event instruction pulse |
| sev_i | input | 1 | Send-event instruction pulse |
| exc_ret_thread_i | input | 1 | Last handler returned to thread code (pulse) |
| dbg_req_i | input | 1 | Debug wake request |
| irq_pend_i | input | N_IRQ | Per-interrupt pending levels |
| irq_en_i | input | N_IRQ | Per-interrupt enable bits |
| irq_prio_i | input | N_IRQ*PRIO_W | Per-interrupt priorities, lower is more urgent |
| cur_prio_i | input | PRIO_W | Current execution priority |
| primask_i | input | 1 | Global interrupt mask |
| sleep_on_exit_i | input | 1 | Enable sleep on return to thread code |
| wake_any_pend_i | input | 1 | Enable event on any newly pending interrupt |
| sleep_o | output | 1 | Core halted |
| wake_o | output | 1 | One-cycle wake pulse |
| take_exc_o | output | 1 | Grant to enter the exception handler |

## Verification
The event latch cannot be read at the ports. A wrong latch value shows up on `sleep_o` one edge after the next wait-for-event: the core either sleeps when it should not or fails to sleep. For that reason the stimulus always follows each event-setting action with one or two wait-for-event pulses. A wrong sleep state, such as a state that mixes up the two wake rules, shows up when a newly pending disabled interrupt arrives. The core wakes or fails to wake on the edge after that interrupt, and `wake_o` is wrong in the same cycle. A bad edge detector is exposed by holding a pending bit high across a later wait-for-event.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_SLP_INT = 2'd1,
    ST_SLP_EVT = 2'd2
  } swc_state_e;
endpackage

// File: rtl/swc_irq_qual.sv
module swc_irq_qual #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IRQ-1:0]        pend_i,
  input  logic [N_IRQ-1:0]        en_i,
  input  logic [N_IRQ*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       cur_prio_i,
  output logic                    any_qual_o,
  output logic                    any_new_o
);
  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] qual_vec;
  logic [N_IRQ-1:0] new_vec;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    assign qual_vec[g] = pend_i[g] & en_i[g] &
                         (prio_i[g*PRIO_W +: PRIO_W] < cur_prio_i);
    assign new_vec[g]  = pend_i[g] & ~pend_q[g];
  end

  assign any_qual_o = |qual_vec;
  assign any_new_o  = |new_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_i;
  end

  // R11: a pending level that was already high on the last edge is not new
  a_r11_level_not_new: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == $past(pend_i)) |-> !any_new_o);
endmodule

// File: rtl/swc_event_latch.sv
module swc_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic consume_i,
  output logic ev_o
);
  logic ev_q;
  logic ev_d;

  always_comb begin
    ev_d = ev_q;
    if (set_i)     ev_d = 1'b1;
    if (consume_i) ev_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= 1'b0;
    else        ev_q <= ev_d;
  end

  assign ev_o = ev_q;

  a_r4_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    consume_i |=> !ev_o);
  a_r5_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !consume_i) |=> ev_o);
endmodule

// File: rtl/swc_sleep_fsm.sv
module swc_sleep_fsm
  import swc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfi_i,
  input  logic       wfe_i,
  input  logic       exit_go_i,
  input  logic       ev_eff_i,
  input  logic       qual_i,
  input  logic       dbg_i,
  input  logic       new_wake_i,
  output logic       consume_o,
  output logic       awake_o,
  output logic       sleep_o,
  output logic       wake_o
);
  swc_state_e state_q, state_d;
  logic       wake_q, wake_d;
  logic       wake_cond;

  assign wake_cond = qual_i | dbg_i;

  always_comb begin
    state_d   = state_q;
    consume_o = 1'b0;
    unique case (state_q)
      ST_AWAKE: begin
        if (wfi_i) begin
          if (!wake_cond) state_d = ST_SLP_INT;
        end else if (wfe_i) begin
          consume_o = 1'b1;
          if (!(ev_eff_i || wake_cond)) state_d = ST_SLP_EVT;
        end else if (exit_go_i && !wake_cond) begin
          state_d = ST_SLP_INT;
        end
      end
      ST_SLP_INT: if (wake_cond) state_d = ST_AWAKE;
      ST_SLP_EVT: if (wake_cond || new_wake_i) state_d = ST_AWAKE;
      default:    state_d = ST_AWAKE;
    endcase
    wake_d = (state_q != ST_AWAKE) && (state_d == ST_AWAKE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign awake_o = (state_q == ST_AWAKE);
  assign sleep_o = !awake_o;
  assign wake_o  = wake_q;

  a_r7_int_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLP_INT && !qual_i && !dbg_i) |=> sleep_o);
  a_r9_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
  a_r9_sleep_falls_with_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!sleep_o && $past(sleep_o)));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wfi_i,
  input  logic                    wfe_i,
  input  logic                    sev_i,
  input  logic                    exc_ret_thread_i,
  input  logic                    dbg_req_i,
  input  logic [N_IRQ-1:0]        irq_pend_i,
  input  logic [N_IRQ-1:0]        irq_en_i,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
  input  logic [PRIO_W-1:0]       cur_prio_i,
  input  logic                    primask_i,
  input  logic                    sleep_on_exit_i,
  input  logic                    wake_any_pend_i,
  output logic                    sleep_o,
  output logic                    wake_o,
  output logic                    take_exc_o
);
  logic any_qual, any_new, new_wake, ev_set, ev_q, consume, awake;

  swc_irq_qual #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (irq_pend_i),
    .en_i       (irq_en_i),
    .prio_i     (irq_prio_i),
    .cur_prio_i (cur_prio_i),
    .any_qual_o (any_qual),
    .any_new_o  (any_new)
  );

  assign new_wake = wake_any_pend_i & any_new;
  assign ev_set   = sev_i | new_wake;

  swc_event_latch u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (ev_set),
    .consume_i (consume),
    .ev_o      (ev_q)
  );

  swc_sleep_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wfi_i      (wfi_i),
    .wfe_i      (wfe_i),
    .exit_go_i  (exc_ret_thread_i & sleep_on_exit_i),
    .ev_eff_i   (ev_q | ev_set),
    .qual_i     (any_qual),
    .dbg_i      (dbg_req_i),
    .new_wake_i (new_wake),
    .consume_o  (consume),
    .awake_o    (awake),
    .sleep_o    (sleep_o),
    .wake_o     (wake_o)
  );

  assign take_exc_o = awake & any_qual & ~primask_i;

  a_r10_no_grant_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !take_exc_o);
  a_r10_mask_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
    primask_i |-> !take_exc_o);
endmodule

// File: tb/sleep_wake_ctrl_tb.sv
module sleep_wake_ctrl_tb;
  localparam int N  = 8;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi = 0, wfe = 0, sev = 0, exr = 0, dbg = 0;
  logic [N-1:0]    pend = '0, en = '0;
  logic [N*PW-1:0] prio = '0;
  logic [PW-1:0]   cur = '0;
  logic primask = 0, soe = 0, wany = 0;
  logic sleep_w, wake_w, take_w;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  int m_state = 0;
  bit m_ev = 0, m_wake = 0;
  bit [N-1:0] m_prev = '0;

  always #2 clk = ~clk;

  sleep_wake_ctrl #(.N_IRQ(N), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wfe_i(wfe), .sev_i(sev),
    .exc_ret_thread_i(exr), .dbg_req_i(dbg), .irq_pend_i(pend),
    .irq_en_i(en), .irq_prio_i(prio), .cur_prio_i(cur), .primask_i(primask),
    .sleep_on_exit_i(soe), .wake_any_pend_i(wany),
    .sleep_o(sleep_w), .wake_o(wake_w), .take_exc_o(take_w)
  );

  function automatic bit m_qual();
    for (int i = 0; i < N; i++)
      if (pend[i] && en[i] && (int'(prio[i*PW +: PW]) < int'(cur))) return 1;
    return 0;
  endfunction

  function automatic bit m_newp();
    for (int i = 0; i < N; i++)
      if (pend[i] && !m_prev[i]) return 1;
    return 0;
  endfunction

  task automatic chk(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc();
    bit q, nw, es, ee, wc, cons;
    int ns;
    #1;
    q = m_qual();
    chk("take_exc", take_w, (m_state == 0 && q && !primask) ? 1 : 0);
    nw = wany && m_newp();
    es = sev || nw;
    ee = m_ev || es;
    wc = q || dbg;
    ns = m_state;
    cons = 0;
    if (m_state == 0) begin
      if (wfi) begin
        if (!wc) ns = 1;
      end else if (wfe) begin
        cons = 1;
        if (!(ee || wc)) ns = 2;
      end else if (exr && soe && !wc) ns = 1;
    end else if (m_state == 1) begin
      if (wc) ns = 0;
    end else if (wc || nw) ns = 0;
    @(posedge clk);
    m_wake = (m_state != 0 && ns == 0);
    m_state = ns;
    if (cons) m_ev = 0; else if (es) m_ev = 1;
    m_prev = pend;
    #1;
    chk("sleep", sleep_w, m_state != 0 ? 1 : 0);
    chk("wake", wake_w, m_wake ? 1 : 0);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic set_prio(int i, int p);
    prio[i*PW +: PW] = p[PW-1:0];
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cur = 3'd4;
    repeat (3) @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    #1;
    chk("sleep in reset", sleep_w, 0);
    chk("wake in reset", wake_w, 0);
    chk("take in reset", take_w, 0);
    rst_n = 1;
    @(negedge clk);
    idle(2);
    wfe = 1; cyc(); wfe = 0;           // R1: cleared latch lets WFE sleep
    idle(2);
    cur_req = "R8"; dbg = 1; cyc(); dbg = 0; idle(2);

    // R2 and R7: WFI sleep, only a qualifying interrupt wakes it
    cur_req = "R2"; wfi = 1; cyc(); wfi = 0; idle(1);
    cur_req = "R7"; wany = 1;
    pend[0] = 1; en[0] = 0; set_prio(0, 0); idle(3);
    pend[1] = 1; en[1] = 1; set_prio(1, 5); idle(3);
    set_prio(1, 4); idle(2);           // equal priority does not qualify
    cur_req = "R10"; primask = 1;
    pend[2] = 1; en[2] = 1; set_prio(2, 1); idle(3);  // R9 wake, grant held
    cur_req = "R9"; idle(1);
    cur_req = "R10"; primask = 0; idle(2);
    pend = '0; wany = 0; idle(2);

    // R3: wake condition already present
    cur_req = "R3"; pend[2] = 1; wfi = 1; cyc(); wfi = 0;
    exr = 1; soe = 1; cyc(); exr = 0; soe = 0; idle(1);
    pend[2] = 0; dbg = 1; wfi = 1; cyc(); wfi = 0; dbg = 0; idle(2);

    // R4 and R5: event latch
    cur_req = "R5"; sev = 1; cyc(); sev = 0; idle(1);
    cur_req = "R4"; wfe = 1; cyc(); wfe = 0; idle(1);
    wfe = 1; cyc(); wfe = 0; idle(2);
    dbg = 1; cyc(); dbg = 0; idle(1);
    cur_req = "R5"; sev = 1; cyc(); sev = 0;
    dbg = 1; cyc(); dbg = 0;
    wfe = 1; cyc(); wfe = 0; idle(1);
    wfe = 1; cyc(); wfe = 0; idle(1);
    dbg = 1; cyc(); dbg = 0; idle(1);

    // R6: sleep on return to thread code
    cur_req = "R6"; exr = 1; cyc(); exr = 0; idle(1);
    soe = 1; exr = 1; cyc(); exr = 0; idle(3);
    pend[3] = 1; en[3] = 1; set_prio(3, 0); idle(2);
    pend = '0; soe = 0; idle(1);

    // R8: WFE wake on any new pending bit only with the enable set
    cur_req = "R8"; wfe = 1; cyc(); wfe = 0; idle(1);
    pend[5] = 1; idle(3);
    wany = 1; pend[6] = 1; idle(2);
    wfe = 1; cyc(); wfe = 0; idle(1);  // latch set by that edge: no sleep
    wfe = 1; cyc(); wfe = 0; idle(2);  // levels held high: sleeps
    pend[2] = 1; en[2] = 1; set_prio(2, 1); idle(2);
    pend = '0; en = '0; idle(1);

    // R11: new pending while awake sets the latch
    cur_req = "R11"; pend[4] = 1; idle(2);
    wfe = 1; cyc(); wfe = 0; idle(1);
    wfe = 1; cyc(); wfe = 0; idle(2);
    dbg = 1; cyc(); dbg = 0;
    pend = '0; wany = 0; idle(2);

    // R12: simultaneous requests
    cur_req = "R12"; wfe = 1; sev = 1; cyc(); wfe = 0; sev = 0; idle(1);
    wfe = 1; cyc(); wfe = 0; idle(1);
    dbg = 1; cyc(); dbg = 0;
    sev = 1; cyc(); sev = 0;
    wfi = 1; wfe = 1; cyc(); wfi = 0; wfe = 0; idle(1);
    dbg = 1; cyc(); dbg = 0;
    wfe = 1; cyc(); wfe = 0; idle(1);  // latch survived: stays awake
    soe = 1; exr = 1; wfe = 1; cyc(); exr = 0; wfe = 0; soe = 0; idle(2);
    dbg = 1; cyc(); dbg = 0; idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule